// File: doc/BRIEF.md
# Capture and Reload Companion for a Core Timer

This block sits beside an up-counting core timer and gives it two auxiliary 16-bit registers. Each register can run as a free counter of its own, capture the core count when its own input pin changes, or act as a reload source that writes its value into the core timer when a trigger fires. The trigger is either an edge on the register's pin or a chosen transition of the core's toggle latch. The block halts while it captures or reloads and does not count.

The core timer is not part of the block. The block reads the core count, an overflow strobe and the present latch level. It returns a load request with a load value. The core's own software write path also passes through the block, and a same-cycle reload takes precedence over it. If register 0 reloads on the latch's rising transition and register 1 on its falling one, the core needs no software help to produce a PWM waveform on its latch. Each phase lasts 0x10000 minus the reloaded value in core ticks.

Top module: `capreload_unit`

## Requirements
- R1: After reset both auxiliary registers read 0 and both interrupt pulses are low. With `coreWrEn` low, `coreLoadEn` is low.
- R2: The mode field of register i is `auxMode[2i+1:2i]`, with 0 free-run, 1 capture, 2 reload and 3 halt. In free-run the register adds one on each clock edge where `auxTick` is high and wraps from 0xFFFF to 0. In the other three modes it does not count.
- R3: The edge field of register i is `auxEdge[2i+1:2i]`, with 0 none, 1 rising, 2 falling and 3 both. In capture mode, a pin change whose direction is enabled copies `coreCount` into the register. The copy happens at the first clock edge at which the pin differs from its value at the previous edge.
- R4: In capture mode with edge field 0, pin changes leave the register unchanged and raise no interrupt.
- R5: The trigger field of register i is `auxTrig[2i+1:2i]`. With trigger 0 in reload mode, an enabled pin edge (edge field as in R3) raises `coreLoadEn` with `coreLoadData` equal to the register. This happens combinationally, during the cycle in which the pin first differs from its previous sampled value.
- R6: Trigger 1 selects the latch rising transition (`coreOverflow` high while `coreLatch` is low). Trigger 2 selects the falling transition (`coreOverflow` high while `coreLatch` is high). Trigger 3 selects either. The reload is requested in that same overflow cycle and at no other time.
- R7: A reload takes precedence over `coreWrEn` on the load port. If both registers reload in one cycle, register 0 supplies the value. Without a reload, `coreWrEn` and `coreWrData` pass straight to `coreLoadEn` and `coreLoadData`.
- R8: Each capture or reload on register i makes `auxIrq[i]` high for exactly the one cycle that follows the event edge.
- R9: `auxWrEn[i]` loads `auxWrData` into register i at the next edge. A capture in the same cycle takes precedence over the write.
- R10: With register 0 reloading on rising transitions and register 1 on falling transitions, and the core ticking every cycle, the latch stays high for 0x10000 minus register 0 cycles and low for 0x10000 minus register 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| auxTick | input | 1 | Count enable for free-running auxiliary registers |
| auxMode | input | 4 | Two-bit mode per register |
| auxEdge | input | 4 | Two-bit pin edge select per register |
| auxTrig | input | 4 | Two-bit reload trigger select per register |
| auxPin | input | 2 | Input pin per register |
| auxWrEn | input | 2 | Software write strobe per register |
| auxWrData | input | 16 | Software write value |
| auxValue | output | 32 | Register 0 in bits 15:0, register 1 in bits 31:16 |
| auxIrq | output | 2 | One-cycle event pulse per register |
| coreCount | input | 16 | Present core timer count |
| coreOverflow | input | 1 | Core wraps and toggles its latch at the coming edge |
| coreLatch | input | 1 | Present core toggle latch level |
| coreWrEn | input | 1 | Software write request for the core |
| coreWrData | input | 16 | Software write value for the core |
| coreLoadEn | output | 1 | Load request to the core |
| coreLoadData | output | 16 | Value the core loads |

## Verification
A bench model of the core counts, wraps and toggles its latch, and the PWM phases are measured on that latch. A reload that is late by one cycle would stretch every phase by one. A reload that fires on both latch transitions would bring register 0's value into the low phase. The bench sends random capture stimulus over all edge settings and pin level pairs. Any mistake in the edge decode shows up as a capture that should not happen or one that is missing, and the capture value shows whether the copy comes from the right edge. Directed cases set a reload against a core write in the same cycle, both registers reloading together, a capture against a software write, and free-run wrap at 0xFFFF. These cases expose a wrong priority or a missing wrap.

// File: rtl/capreload_pkg.sv
package capreload_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_RELOAD  = 2'd2,
    MODE_HALT    = 2'd3
  } auxMode_e;

  typedef enum logic [1:0] {
    TRIG_PIN        = 2'd0,
    TRIG_LATCH_RISE = 2'd1,
    TRIG_LATCH_FALL = 2'd2,
    TRIG_LATCH_ANY  = 2'd3
  } trigSel_e;

  // Per-register strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic reload;
    logic count;
    logic write;
  } auxStrobe_t;

endpackage

// File: rtl/capreload_ctrl.sv
module capreload_ctrl
  import capreload_pkg::*;
#(
  parameter int NumAux = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          auxTick,
  input  logic [2*NumAux-1:0]           auxMode,
  input  logic [2*NumAux-1:0]           auxEdge,
  input  logic [2*NumAux-1:0]           auxTrig,
  input  logic [NumAux-1:0]             auxPin,
  input  logic [NumAux-1:0]             auxWrEn,
  input  logic                          coreOverflow,
  input  logic                          coreLatch,
  output auxStrobe_t [NumAux-1:0]       strobe
);

  // Pin history tracks the pins through reset as well, so leaving reset
  // never shows a spurious edge.
  logic [NumAux-1:0] pinPrev;

  always_ff @(posedge clk) begin
    pinPrev <= auxPin;
  end

  logic latchRise, latchFall;
  assign latchRise = coreOverflow & ~coreLatch;
  assign latchFall = coreOverflow & coreLatch;

  for (genvar i = 0; i < NumAux; i++) begin : g_aux
    auxMode_e mode;
    trigSel_e trig;
    logic     rise, fall, pinHit, trigHit;

    assign mode   = auxMode_e'(auxMode[2*i +: 2]);
    assign trig   = trigSel_e'(auxTrig[2*i +: 2]);
    assign rise   = auxPin[i] & ~pinPrev[i];
    assign fall   = ~auxPin[i] & pinPrev[i];
    assign pinHit = (auxEdge[2*i] & rise) | (auxEdge[2*i+1] & fall);

    always_comb begin
      case (trig)
        TRIG_PIN:        trigHit = pinHit;
        TRIG_LATCH_RISE: trigHit = latchRise;
        TRIG_LATCH_FALL: trigHit = latchFall;
        default:         trigHit = coreOverflow;
      endcase
    end

    assign strobe[i].capture = (mode == MODE_CAPTURE) & pinHit;
    assign strobe[i].reload  = (mode == MODE_RELOAD) & trigHit;
    assign strobe[i].count   = (mode == MODE_FREE) & auxTick;
    assign strobe[i].write   = auxWrEn[i];

    // A capture needs the pin to have moved since the previous edge
    assert_capture_on_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].capture |-> (auxPin[i] != $past(auxPin[i])));

    // Latch-sourced reloads only ever happen in an overflow cycle
    assert_latch_reload_needs_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!coreOverflow && (trig != TRIG_PIN)) |-> !strobe[i].reload);
  end

endmodule

// File: rtl/capreload_datapath.sv
module capreload_datapath
  import capreload_pkg::*;
#(
  parameter int NumAux = 2,
  parameter int Width  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  auxStrobe_t [NumAux-1:0]   strobe,
  input  logic [Width-1:0]          auxWrData,
  input  logic [Width-1:0]          coreCount,
  input  logic                      coreWrEn,
  input  logic [Width-1:0]          coreWrData,
  output logic [NumAux*Width-1:0]   auxValue,
  output logic [NumAux-1:0]         auxIrq,
  output logic                      coreLoadEn,
  output logic [Width-1:0]          coreLoadData
);

  logic [Width-1:0]  regArr [NumAux];
  logic [NumAux-1:0] reloadVec;

  for (genvar i = 0; i < NumAux; i++) begin : g_reg
    logic [Width-1:0] regQ;
    logic             irqQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ <= '0;
        irqQ <= 1'b0;
      end else begin
        if (strobe[i].capture)    regQ <= coreCount;
        else if (strobe[i].write) regQ <= auxWrData;
        else if (strobe[i].count) regQ <= regQ + 1'b1;
        irqQ <= strobe[i].capture | strobe[i].reload;
      end
    end

    assign regArr[i]                   = regQ;
    assign auxValue[i*Width +: Width]  = regQ;
    assign auxIrq[i]                   = irqQ;
    assign reloadVec[i]                = strobe[i].reload;

    assert_capture_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].capture |=> (auxValue[i*Width +: Width] == $past(coreCount)));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe[i].capture | strobe[i].write | strobe[i].count)
        |=> $stable(auxValue[i*Width +: Width]));

    assert_irq_after_event_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[i].capture | strobe[i].reload) |=> auxIrq[i]);

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe[i].capture | strobe[i].reload) |=> !auxIrq[i]);
  end

  // Lowest index wins when several registers reload together
  logic             reloadAny;
  logic [Width-1:0] reloadVal;

  always_comb begin
    reloadAny = 1'b0;
    reloadVal = '0;
    for (int k = NumAux - 1; k >= 0; k--) begin
      if (reloadVec[k]) begin
        reloadAny = 1'b1;
        reloadVal = regArr[k];
      end
    end
  end

  assign coreLoadEn   = reloadAny | coreWrEn;
  assign coreLoadData = reloadAny ? reloadVal : coreWrData;

  assert_reload_first_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    reloadVec[0] |-> (coreLoadEn && coreLoadData == auxValue[Width-1:0]));

  assert_write_passthrough_R7: assert property (@(posedge clk) disable iff (!rstN)
    (coreWrEn && reloadVec == '0) |-> (coreLoadEn && coreLoadData == coreWrData));

endmodule

// File: rtl/capreload_unit.sv
module capreload_unit
  import capreload_pkg::*;
#(
  parameter int Width  = 16,
  parameter int NumAux = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      auxTick,
  input  logic [2*NumAux-1:0]       auxMode,
  input  logic [2*NumAux-1:0]       auxEdge,
  input  logic [2*NumAux-1:0]       auxTrig,
  input  logic [NumAux-1:0]         auxPin,
  input  logic [NumAux-1:0]         auxWrEn,
  input  logic [Width-1:0]          auxWrData,
  output logic [NumAux*Width-1:0]   auxValue,
  output logic [NumAux-1:0]         auxIrq,
  input  logic [Width-1:0]          coreCount,
  input  logic                      coreOverflow,
  input  logic                      coreLatch,
  input  logic                      coreWrEn,
  input  logic [Width-1:0]          coreWrData,
  output logic                      coreLoadEn,
  output logic [Width-1:0]          coreLoadData
);

  auxStrobe_t [NumAux-1:0] strobe;

  capreload_ctrl #(.NumAux(NumAux)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .auxTick      (auxTick),
    .auxMode      (auxMode),
    .auxEdge      (auxEdge),
    .auxTrig      (auxTrig),
    .auxPin       (auxPin),
    .auxWrEn      (auxWrEn),
    .coreOverflow (coreOverflow),
    .coreLatch    (coreLatch),
    .strobe       (strobe)
  );

  capreload_datapath #(.NumAux(NumAux), .Width(Width)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .auxWrData    (auxWrData),
    .coreCount    (coreCount),
    .coreWrEn     (coreWrEn),
    .coreWrData   (coreWrData),
    .auxValue     (auxValue),
    .auxIrq       (auxIrq),
    .coreLoadEn   (coreLoadEn),
    .coreLoadData (coreLoadData)
  );

endmodule

// File: tb/tb_capreload_unit.sv
`timescale 1ns/1ps
module tb_capreload_unit;

  localparam logic [1:0] M_FREE = 2'd0, M_CAP = 2'd1, M_REL = 2'd2, M_HALT = 2'd3;
  localparam logic [1:0] T_PIN = 2'd0, T_RISE = 2'd1, T_FALL = 2'd2, T_ANY = 2'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        auxTick = 1'b0;
  logic [3:0]  auxMode = 4'hF;
  logic [3:0]  auxEdge = 4'h0;
  logic [3:0]  auxTrig = 4'h0;
  logic [1:0]  auxPin = 2'b00;
  logic [1:0]  auxWrEn = 2'b00;
  logic [15:0] auxWrData = '0;
  logic [31:0] auxValue;
  logic [1:0]  auxIrq;
  logic [15:0] coreCount;
  logic        coreOverflow;
  logic        coreLatch;
  logic        coreWrEn = 1'b0;
  logic [15:0] coreWrData = '0;
  logic        coreLoadEn;
  logic [15:0] coreLoadData;
  logic        coreTick = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  capreload_unit dut (
    .clk(clk), .rstN(rstN), .auxTick(auxTick), .auxMode(auxMode),
    .auxEdge(auxEdge), .auxTrig(auxTrig), .auxPin(auxPin), .auxWrEn(auxWrEn),
    .auxWrData(auxWrData), .auxValue(auxValue), .auxIrq(auxIrq),
    .coreCount(coreCount), .coreOverflow(coreOverflow), .coreLatch(coreLatch),
    .coreWrEn(coreWrEn), .coreWrData(coreWrData), .coreLoadEn(coreLoadEn),
    .coreLoadData(coreLoadData)
  );

  // Behavioural core timer: counts up, toggles latch on wrap, obeys load port
  assign coreOverflow = coreTick && (coreCount == 16'hFFFF);
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreCount <= '0;
      coreLatch <= 1'b0;
    end else begin
      if (coreLoadEn)    coreCount <= coreLoadData;
      else if (coreTick) coreCount <= coreCount + 16'd1;
      if (coreOverflow)  coreLatch <= ~coreLatch;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic edgeHit(logic [1:0] sel, logic from, logic to);
    return (sel[0] & ~from & to) | (sel[1] & from & ~to);
  endfunction

  function automatic logic [15:0] auxOf(int i);
    return (i == 0) ? auxValue[15:0] : auxValue[31:16];
  endfunction

  task automatic setCfg(int i, logic [1:0] mode, logic [1:0] edgeSel, logic [1:0] trig);
    auxMode[2*i +: 2] = mode;
    auxEdge[2*i +: 2] = edgeSel;
    auxTrig[2*i +: 2] = trig;
  endtask

  task automatic writeAux(int i, logic [15:0] val);
    auxWrData = val;
    auxWrEn[i] = 1'b1;
    @(negedge clk);
    auxWrEn = 2'b00;
  endtask

  task automatic writeCore(logic [15:0] val);
    coreWrData = val;
    coreWrEn = 1'b1;
    @(negedge clk);
    coreWrEn = 1'b0;
  endtask

  // Measure latch phases after an autonomous PWM start
  task automatic runPwm(int hiLen, int loLen);
    logic prevLvl;
    int   run;
    int   seen;
    setCfg(0, M_HALT, 2'd0, T_PIN);
    setCfg(1, M_HALT, 2'd0, T_PIN);
    writeAux(0, 16'(32'h10000 - hiLen));
    writeAux(1, 16'(32'h10000 - loLen));
    setCfg(0, M_REL, 2'd0, T_RISE);
    setCfg(1, M_REL, 2'd0, T_FALL);
    writeCore(16'hFFFC);
    coreTick = 1'b1;
    prevLvl = coreLatch;
    run = 0;
    seen = 0;
    for (int c = 0; c < 400 && seen < 5; c++) begin
      @(negedge clk);
      if (coreLatch == prevLvl) run++;
      else begin
        if (seen > 0)
          check(prevLvl ? "R10 high phase" : "R10 low phase", run,
                prevLvl ? hiLen : loLen);
        seen++;
        prevLvl = coreLatch;
        run = 1;
      end
    end
    check("R10 phase count", seen, 5);
    coreTick = 1'b0;
    setCfg(0, M_HALT, 2'd0, T_PIN);
    setCfg(1, M_HALT, 2'd0, T_PIN);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] expV;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 aux values", auxValue, 32'h0);
    check("R1 irq", {30'd0, auxIrq}, 32'h0);
    check("R1 load", {31'd0, coreLoadEn}, 32'h0);

    // R9: software writes
    writeAux(0, 16'h1234);
    writeAux(1, 16'hBEEF);
    check("R9 write aux0", auxOf(0), 32'h1234);
    check("R9 write aux1", auxOf(1), 32'hBEEF);

    // R2: free-run counting with a random tick pattern, other register bound
    setCfg(0, M_FREE, 2'd0, T_PIN);
    setCfg(1, M_CAP, 2'd0, T_PIN);
    expV = 16'h1234;
    for (int c = 0; c < 40; c++) begin
      auxTick = 1'($urandom % 2);
      if (auxTick) expV++;
      @(negedge clk);
    end
    auxTick = 1'b0;
    check("R2 free-run count", auxOf(0), expV);
    check("R2 capture mode holds", auxOf(1), 32'hBEEF);
    setCfg(1, M_REL, 2'd0, T_PIN);
    auxTick = 1'b1;
    repeat (3) @(negedge clk);
    auxTick = 1'b0;
    check("R2 reload mode holds", auxOf(1), 32'hBEEF);
    writeAux(0, 16'hFFFF);
    auxTick = 1'b1;
    @(negedge clk);
    auxTick = 1'b0;
    check("R2 wrap to zero", auxOf(0), 32'h0);

    // R3/R4: random capture trials across all edge selects
    for (int it = 0; it < 40; it++) begin
      int          i;
      logic [1:0]  sel;
      logic        startLvl, endLvl, hit;
      logic [15:0] cv;
      i = it % 2;
      sel = 2'($urandom % 4);
      if (it < 4) sel = 2'd0;
      startLvl = 1'($urandom % 2);
      endLvl = (it < 4) ? ~startLvl : 1'($urandom % 2);
      cv = 16'($urandom);
      setCfg(0, M_HALT, 2'd0, T_PIN);
      setCfg(1, M_HALT, 2'd0, T_PIN);
      setCfg(i, M_CAP, 2'd0, T_PIN);
      auxPin[i] = startLvl;
      auxWrData = 16'hA5A5;
      auxWrEn[i] = 1'b1;
      coreWrData = cv;
      coreWrEn = 1'b1;
      @(negedge clk);
      auxWrEn = 2'b00;
      coreWrEn = 1'b0;
      auxEdge[2*i +: 2] = sel;
      auxPin[i] = endLvl;
      @(negedge clk);
      hit = edgeHit(sel, startLvl, endLvl);
      check(sel == 2'd0 ? "R4 no capture" : "R3 capture value", auxOf(i),
            hit ? cv : 16'hA5A5);
      check(sel == 2'd0 ? "R4 no irq" : "R8 capture irq", {31'd0, auxIrq[i]}, {31'd0, hit});
      @(negedge clk);
      check("R8 irq one cycle", {31'd0, auxIrq[i]}, 32'h0);
    end

    // R9: capture beats a same-cycle write
    setCfg(0, M_CAP, 2'd3, T_PIN);
    auxPin[0] = 1'b0;
    @(negedge clk);
    writeCore(16'h5A5A);
    auxWrData = 16'h0F0F;
    auxWrEn[0] = 1'b1;
    auxPin[0] = 1'b1;
    @(negedge clk);
    auxWrEn = 2'b00;
    check("R9 capture over write", auxOf(0), 32'h5A5A);

    // R5: pin-triggered reload
    setCfg(0, M_HALT, 2'd0, T_PIN);
    setCfg(1, M_HALT, 2'd0, T_PIN);
    auxPin = 2'b00;
    writeAux(1, 16'h4321);
    setCfg(1, M_REL, 2'd1, T_PIN);
    auxPin[1] = 1'b1;
    #2;
    check("R5 load request", {31'd0, coreLoadEn}, 32'h1);
    check("R5 load value", coreLoadData, 32'h4321);
    @(negedge clk);
    check("R5 core loaded", coreCount, 32'h4321);
    check("R8 reload irq", {30'd0, auxIrq}, 32'h2);
    check("R5 single request", {31'd0, coreLoadEn}, 32'h0);

    // R7: priority on the load port
    auxPin = 2'b00;
    writeAux(0, 16'h1111);
    writeAux(1, 16'h2222);
    setCfg(0, M_REL, 2'd1, T_PIN);
    setCfg(1, M_REL, 2'd1, T_PIN);
    coreWrData = 16'h7777;
    coreWrEn = 1'b1;
    auxPin = 2'b11;
    #2;
    check("R7 reg0 over reg1 and write", coreLoadData, 32'h1111);
    @(negedge clk);
    coreWrEn = 1'b0;
    check("R7 core got reload", coreCount, 32'h1111);
    auxPin = 2'b10;
    writeCore(16'h7777);
    check("R7 write passes", coreCount, 32'h7777);
    auxPin = 2'b00;

    // R6: either-transition trigger requests in each overflow cycle
    setCfg(0, M_HALT, 2'd0, T_PIN);
    setCfg(1, M_HALT, 2'd0, T_PIN);
    writeAux(0, 16'hFFFD);
    setCfg(0, M_REL, 2'd0, T_ANY);
    writeCore(16'hFFF0);
    coreTick = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      #1;
      check("R6 request tracks overflow", {31'd0, coreLoadEn}, {31'd0, coreOverflow});
    end
    coreTick = 1'b0;

    // R6/R10: autonomous PWM, directed then random phases
    runPwm(16, 24);
    runPwm(int'($urandom % 30) + 2, int'($urandom % 30) + 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule